// File: doc/BRIEF.md
# Alarm-Driven Power-Enable Controller

This block sits beside a BCD calendar counter and owns the power-enable line of an external power-management chip. A dedicated compare alarm watches the running BCD time. When every field of the time matches the programmed alarm, and the alarm is armed, the block sets a sticky status bit and can raise an interrupt. If software has handed the power-enable line to the block, the same event drives that line to its off level, so the supply chip shuts the system down.

Four external wake lines can bring power back. Each line has its own enable bit and its own polarity bit. A line is first synchronised into the bus clock domain. It must then hold one level for a set number of slow-tick periods before it counts. An enabled line that reaches its active level drives the power-enable line back on and sets a per-line wake status bit.

Software reaches the alarm fields and the control bits through a simple word-wide register bus. All writes are word writes, and reads are combinational.

Top module: `pmic_pwr_ctrl`

## Requirements
- R1: After reset, pmic_power_en_o is 1 (on), alarm2_sts_o and irq_o are 0, and the power word at 0x98 reads 0x000000F0: all wake enables are clear, all polarity bits are set, wake status is clear and the hand-over bit 16 is clear.
- R2: The alarm compare bytes sit at 0x80 (seconds), 0x84 (minutes), 0x88 (hours), 0x8C (day), 0x90 (month) and 0x94 (year). Each takes wdata_i[7:0] and reads back in rdata_o[7:0]. time_i packs seconds in [7:0] up to year in [47:40].
- R3: The alarm fires only when bit 4 of the arm word at 0x48 is set and all six bytes equal time_i, on the first cycle of equality. A field that differs, a missing arm bit, or equality that simply persists does not fire. A firing sets alarm2_sts_o (bit 7 of 0x44) on the next clock edge.
- R4: Writing 1 to bit 7 of 0x44 clears alarm2_sts_o. A firing in the same cycle wins over the clear.
- R5: irq_o is high exactly when alarm2_sts_o is set and the arm bit is set.
- R6: A firing drives pmic_power_en_o to 0 on the same edge that sets the status, but only while bit 16 of 0x98 is set. Otherwise pmic_power_en_o is left unchanged.
- R7: Each wake line passes through two flip-flops. Its level must then stay unchanged for 4 slow ticks (tick_i pulses) before the qualified level follows it. Shorter pulses are ignored.
- R8: In 0x98, bit n (n=0..3) enables wake line n, and bit 4+n sets its polarity: 1 means active low, 0 means active high. A disabled line has no effect.
- R9: When an enabled line's qualified level becomes active, pmic_power_en_o goes to 1 and wake status bit 8+n of 0x98 is set on the next edge. A wake wins over an alarm power-off in the same cycle. Writing 1 to bit 8+n clears that status bit, and a new wake in the same cycle wins.
- R10: 0x98 is one 32-bit word {15'b0, hand-over[16], 4'b0, wake status[11:8], polarity[7:4], enable[3:0]}. A write sets enable, polarity and hand-over in one access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus and logic clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One-cycle pulse per slow (32 kHz) period |
| time_i | input | 48 | Running BCD time, seconds in the low byte up to year |
| wr_en_i | input | 1 | Word write strobe |
| addr_i | input | 8 | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i |
| wake_i | input | 4 | Asynchronous wake lines |
| pmic_power_en_o | output | 1 | Power-enable to the supply chip, 1 = on |
| alarm2_sts_o | output | 1 | Sticky alarm status |
| irq_o | output | 1 | Alarm interrupt |

## Verification
The properties assume that time_i changes only between clock edges. They also assume each bus write lasts a single cycle with a stable address. The bench drives every input on the falling edge and holds each write for exactly one cycle. The properties also take it that wake lines and time come from outside and may change at any cycle. So the stimulus moves time in and out of equality with the alarm. It also gives wake lines both short glitches and long holds, measured against the tick spacing.

// File: rtl/pmic_pkg.sv
package pmic_pkg;
  localparam int unsigned ADDR_W    = 8;
  localparam int unsigned DATA_W    = 32;
  localparam int unsigned NUM_FIELD = 6;
  localparam int unsigned FIELD_W   = 8;
  localparam int unsigned TIME_W    = NUM_FIELD * FIELD_W;

  localparam logic [ADDR_W-1:0] ADDR_STS  = 8'h44;
  localparam logic [ADDR_W-1:0] ADDR_ARM  = 8'h48;
  localparam logic [ADDR_W-1:0] ADDR_ALM0 = 8'h80;
  localparam logic [ADDR_W-1:0] ADDR_PWR  = 8'h98;

  localparam int unsigned STS_BIT  = 7;
  localparam int unsigned ARM_BIT  = 4;
  localparam int unsigned HAND_BIT = 16;
  localparam int unsigned POL_LSB  = 4;
  localparam int unsigned WSTS_LSB = 8;
endpackage

// File: rtl/alarm2_cmp.sv
module alarm2_cmp
  import pmic_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wbyte_i,
  input  logic [TIME_W-1:0] time_i,
  output logic [TIME_W-1:0] alm_o,
  output logic              hit_o,
  output logic              match_o,
  output logic              match_q_o
);
  logic [NUM_FIELD-1:0] field_eq;

  for (genvar f = 0; f < NUM_FIELD; f++) begin : g_field
    localparam logic [ADDR_W-1:0] FADDR = ADDR_ALM0 + ADDR_W'(4 * f);
    logic [FIELD_W-1:0] fld_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          fld_q <= '0;
      else if (wr_en_i && addr_i == FADDR)  fld_q <= wbyte_i;
    end
    assign alm_o[f*FIELD_W +: FIELD_W] = fld_q;
    assign field_eq[f] = (fld_q == time_i[f*FIELD_W +: FIELD_W]);
  end

  assign hit_o   = (addr_i >= ADDR_ALM0) && (addr_i < ADDR_ALM0 + ADDR_W'(4 * NUM_FIELD))
                   && (addr_i[1:0] == 2'b00);
  assign match_o = &field_eq;

  // starts high so an all-zero time at reset is not seen as a new match
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) match_q_o <= 1'b1;
    else         match_q_o <= match_o;
  end
endmodule

// File: rtl/wake_qual.sv
module wake_qual #(
  parameter int unsigned NUM_WAKE     = 4,
  parameter int unsigned SYNC_STAGES  = 2,
  parameter int unsigned STABLE_TICKS = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                tick_i,
  input  logic [NUM_WAKE-1:0] wake_i,
  output logic [NUM_WAKE-1:0] filt_o
);
  localparam int unsigned CNT_W = $clog2(STABLE_TICKS + 1);

  for (genvar p = 0; p < NUM_WAKE; p++) begin : g_pin
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   last_q;
    logic [CNT_W-1:0]       cnt_q;
    logic                   filt_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sync_q <= '0;
      else         sync_q <= {sync_q[SYNC_STAGES-2:0], wake_i[p]};
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        last_q <= 1'b0;
        cnt_q  <= '0;
        filt_q <= 1'b0;
      end else if (sync_q[SYNC_STAGES-1] != last_q) begin
        last_q <= sync_q[SYNC_STAGES-1];
        cnt_q  <= '0;
      end else if (tick_i && cnt_q != CNT_W'(STABLE_TICKS)) begin
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == CNT_W'(STABLE_TICKS - 1)) filt_q <= last_q;
      end
    end
    assign filt_o[p] = filt_q;
  end
endmodule

// File: rtl/pmic_pwr_ctrl.sv
module pmic_pwr_ctrl
  import pmic_pkg::*;
#(
  parameter int unsigned NUM_WAKE     = 4,
  parameter int unsigned SYNC_STAGES  = 2,
  parameter int unsigned STABLE_TICKS = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic [47:0]       time_i,
  input  logic              wr_en_i,
  input  logic [7:0]        addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  input  logic [3:0]        wake_i,
  output logic              pmic_power_en_o,
  output logic              alarm2_sts_o,
  output logic              irq_o
);
  logic [TIME_W-1:0]   alm;
  logic                alm_hit, match, match_q;
  logic [NUM_WAKE-1:0] filt, active, act_q, wake_evt;
  logic [NUM_WAKE-1:0] en_q, pol_q, wsts_q;
  logic                arm_q, hand_q, sts_q, pwr_q, fire;
  logic                wr_sts, wr_arm, wr_pwr;

  alarm2_cmp u_cmp (
    .clk_i, .rst_ni, .wr_en_i, .addr_i,
    .wbyte_i   (wdata_i[7:0]),
    .time_i,
    .alm_o     (alm),
    .hit_o     (alm_hit),
    .match_o   (match),
    .match_q_o (match_q)
  );

  wake_qual #(
    .NUM_WAKE(NUM_WAKE), .SYNC_STAGES(SYNC_STAGES), .STABLE_TICKS(STABLE_TICKS)
  ) u_wake (
    .clk_i, .rst_ni, .tick_i, .wake_i,
    .filt_o (filt)
  );

  assign wr_sts   = wr_en_i && addr_i == ADDR_STS;
  assign wr_arm   = wr_en_i && addr_i == ADDR_ARM;
  assign wr_pwr   = wr_en_i && addr_i == ADDR_PWR;
  assign fire     = match && !match_q && arm_q;
  // polarity 1 = active low
  assign active   = en_q & (filt ^ pol_q);
  assign wake_evt = active & ~act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= '0;
      pol_q  <= '1;
      hand_q <= 1'b0;
      arm_q  <= 1'b0;
      act_q  <= '0;
    end else begin
      act_q <= active;
      if (wr_arm) arm_q <= wdata_i[ARM_BIT];
      if (wr_pwr) begin
        en_q   <= wdata_i[NUM_WAKE-1:0];
        pol_q  <= wdata_i[POL_LSB +: NUM_WAKE];
        hand_q <= wdata_i[HAND_BIT];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sts_q  <= 1'b0;
      wsts_q <= '0;
      pwr_q  <= 1'b1;
    end else begin
      if (fire)                          sts_q <= 1'b1;
      else if (wr_sts && wdata_i[STS_BIT]) sts_q <= 1'b0;
      wsts_q <= (wsts_q & ~(wr_pwr ? wdata_i[WSTS_LSB +: NUM_WAKE] : '0)) | wake_evt;
      if (|wake_evt)         pwr_q <= 1'b1;
      else if (fire && hand_q) pwr_q <= 1'b0;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (alm_hit) begin
      rdata_o[7:0] = alm[((addr_i - ADDR_ALM0) >> 2) * FIELD_W +: FIELD_W];
    end else begin
      unique case (addr_i)
        ADDR_STS: rdata_o[STS_BIT] = sts_q;
        ADDR_ARM: rdata_o[ARM_BIT] = arm_q;
        ADDR_PWR: begin
          rdata_o[NUM_WAKE-1:0]           = en_q;
          rdata_o[POL_LSB +: NUM_WAKE]    = pol_q;
          rdata_o[WSTS_LSB +: NUM_WAKE]   = wsts_q;
          rdata_o[HAND_BIT]               = hand_q;
        end
        default: rdata_o = '0;
      endcase
    end
  end

  assign pmic_power_en_o = pwr_q;
  assign alarm2_sts_o    = sts_q;
  assign irq_o           = sts_q && arm_q;
endmodule

// File: rtl/pmic_pwr_ctrl_chk.sv
module pmic_pwr_ctrl_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        wr_en_i,
  input logic [7:0]  addr_i,
  input logic [31:0] wdata_i,
  input logic        pwr,
  input logic        sts,
  input logic        irq,
  input logic        hand,
  input logic        arm,
  input logic [3:0]  wsts
);
  AST_OFF_NEEDS_HAND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pwr) |-> $past(hand)); // R6
  AST_OFF_WITH_STS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pwr) |-> sts); // R6
  AST_IRQ_NEEDS_STS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq |-> (sts && arm)); // R5
  AST_ON_FROM_WAKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pwr) |-> (wsts != 4'b0)); // R9
  AST_STS_CLR_BY_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sts) |-> $past(wr_en_i && addr_i == 8'h44 && wdata_i[7])); // R4
  AST_STS_SET_NEEDS_ARM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sts) |-> $past(arm)); // R3
endmodule

bind pmic_pwr_ctrl pmic_pwr_ctrl_chk u_chk (
  .clk_i, .rst_ni, .wr_en_i, .addr_i, .wdata_i,
  .pwr  (pmic_power_en_o),
  .sts  (alarm2_sts_o),
  .irq  (irq_o),
  .hand (hand_q),
  .arm  (arm_q),
  .wsts (wsts_q)
);

// File: tb/pmic_pwr_ctrl_bench.sv
`timescale 1ns/1ps
module pmic_pwr_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic [47:0] time_v = '0;
  logic        we = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [3:0]  wake = 4'hF;
  logic        pwr, sts, irq;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pmic_pwr_ctrl u_pmic_pwr_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .time_i(time_v),
    .wr_en_i(we), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .wake_i(wake), .pmic_power_en_o(pwr), .alarm2_sts_o(sts), .irq_o(irq)
  );

  // tick every 8 cycles
  int tcnt = 0;
  always @(negedge clk) begin
    tcnt = (tcnt + 1) % 8;
    tick <= (tcnt == 0);
  end

  // behavioural reference model
  logic [7:0] m_alm [6];
  bit m_mq, m_arm, m_sts, m_hand, m_pwr;
  bit [3:0] m_en, m_pol, m_wsts, m_act, m_filt, m_last, m_s1, m_s2;
  int m_cnt [4];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      foreach (m_alm[i]) m_alm[i] = 8'h00;
      m_mq = 1; m_arm = 0; m_sts = 0; m_hand = 0; m_pwr = 1;
      m_en = 0; m_pol = 4'hF; m_wsts = 0; m_act = 0; m_filt = 0; m_last = 0;
      m_s1 = 0; m_s2 = 0;
      foreach (m_cnt[i]) m_cnt[i] = 0;
    end else begin
      bit mt, fire;
      bit [3:0] act_now, ev;
      mt = 1;
      for (int f = 0; f < 6; f++) if (m_alm[f] != time_v[f*8 +: 8]) mt = 0;
      fire = mt && !m_mq && m_arm;
      for (int p = 0; p < 4; p++) begin
        act_now[p] = m_en[p] && (m_filt[p] != m_pol[p]);
        ev[p] = act_now[p] && !m_act[p];
      end
      m_act = act_now;
      for (int p = 0; p < 4; p++) begin
        if (m_s2[p] != m_last[p]) begin
          m_last[p] = m_s2[p]; m_cnt[p] = 0;
        end else if (tick && m_cnt[p] < 4) begin
          m_cnt[p]++;
          if (m_cnt[p] == 4) m_filt[p] = m_last[p];
        end
      end
      m_s2 = m_s1; m_s1 = wake;
      if (ev != 0) m_pwr = 1;
      else if (fire && m_hand) m_pwr = 0;
      if (fire) m_sts = 1;
      else if (we && addr == 8'h44 && wdata[7]) m_sts = 0;
      if (we && addr == 8'h98) m_wsts = m_wsts & ~wdata[11:8];
      m_wsts = m_wsts | ev;
      if (we) begin
        if (addr == 8'h48) m_arm = wdata[4];
        if (addr == 8'h98) begin
          m_en = wdata[3:0]; m_pol = wdata[7:4]; m_hand = wdata[16];
        end
        for (int f = 0; f < 6; f++) if (addr == 8'h80 + 4*f) m_alm[f] = wdata[7:0];
      end
      m_mq = mt;
    end
  end

  function automatic logic [31:0] m_read(input logic [7:0] a);
    logic [31:0] r = '0;
    for (int f = 0; f < 6; f++) if (a == 8'h80 + 4*f) r[7:0] = m_alm[f];
    if (a == 8'h44) r[7] = m_sts;
    if (a == 8'h48) r[4] = m_arm;
    if (a == 8'h98) r = {15'b0, m_hand, 4'b0, m_wsts, m_pol, m_en};
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  // every-cycle comparison against the model
  always @(negedge clk) begin
    cyc++;
    if (rst_n && !done) begin
      chk(pwr == m_pwr, "R6/R9 power", pwr, m_pwr);
      chk(sts == m_sts, "R3/R4 status", sts, m_sts);
      chk(irq == (m_sts && m_arm), "R5 irq", irq, m_sts && m_arm);
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); we = 1; addr = a; wdata = d;
    @(negedge clk); we = 0; addr = 8'h00; wdata = '0;
  endtask

  task automatic rd(input logic [7:0] a, input string req);
    @(negedge clk); addr = a; #1;
    chk(rdata == m_read(a), req, rdata, m_read(a));
  endtask

  task automatic rd_lit(input logic [7:0] a, input logic [31:0] exp, input logic [31:0] mask, input string req);
    @(negedge clk); addr = a; #1;
    chk((rdata & mask) == (exp & mask), req, rdata & mask, exp & mask);
  endtask

  localparam logic [47:0] T_ALM  = 48'h24_06_15_12_30_59;
  localparam logic [47:0] T_AWAY = 48'h24_06_15_12_30_58;
  localparam logic [47:0] T_PART = 48'h23_06_15_12_30_59;

  initial begin
    int wd = 0;
    fork
      begin
        while (wd < 100000 && !done) begin @(posedge clk); wd++; end
        if (!done) begin
          errors++; checks++;
          $display("FAIL watchdog: actual=%0d expected<100000", wd);
          done = 1;
          $display("Result: errors=%0d of %0d checks", errors, checks);
          $finish;
        end
      end
    join_none
  end

  initial begin
    idle(3); rst_n = 1; idle(2);
    // R1 reset state
    chk(pwr == 1, "R1 pwr", pwr, 1);
    chk(sts == 0 && irq == 0, "R1 sts/irq", {sts, irq}, 0);
    rd_lit(8'h98, 32'h0000_00F0, 32'hFFFF_FFFF, "R1 power word");
    rd_lit(8'h44, 32'h0, 32'hFFFF_FFFF, "R1 status word");

    // R2 program alarm and read back
    time_v = T_AWAY;
    for (int f = 0; f < 6; f++) wr(8'h80 + 4*f, {24'h0, T_ALM[f*8 +: 8]});
    for (int f = 0; f < 6; f++) rd_lit(8'h80 + 4*f, {24'h0, T_ALM[f*8 +: 8]}, 32'hFF, "R2 alarm byte");

    // R3 equality without arm does not fire
    @(negedge clk) time_v = T_ALM; idle(3);
    chk(sts == 0, "R3 unarmed", sts, 0);
    time_v = T_AWAY;
    wr(8'h48, 32'h10);
    rd_lit(8'h48, 32'h10, 32'hFFFF_FFFF, "R3 arm bit");
    // R3 partial match does not fire
    @(negedge clk) time_v = T_PART; idle(3);
    chk(sts == 0, "R3 partial", sts, 0);
    // R3/R5/R6 full match, hand-over clear
    @(negedge clk) time_v = T_ALM; idle(2);
    chk(sts == 1, "R3 fire", sts, 1);
    chk(irq == 1, "R5 irq", irq, 1);
    chk(pwr == 1, "R6 no hand-over", pwr, 1);
    // R4 clear, persisting equality does not refire
    wr(8'h44, 32'h80); idle(3);
    chk(sts == 0, "R4 cleared", sts, 0);
    chk(irq == 0, "R5 irq low", irq, 0);

    // R6 with hand-over
    wr(8'h98, 32'h0001_00F0);
    rd_lit(8'h98, 32'h0001_00F0, 32'hFFFF_FFFF, "R10 power word");
    @(negedge clk) time_v = T_AWAY; idle(2);
    @(negedge clk) time_v = T_ALM; idle(2);
    chk(pwr == 0, "R6 power off", pwr, 0);

    // R7 glitch on enabled active-low pin 0 is ignored
    wr(8'h98, 32'h0001_00F1); idle(60);
    @(negedge clk) wake[0] = 0; idle(16);
    @(negedge clk) wake[0] = 1; idle(60);
    chk(pwr == 0, "R7 glitch ignored", pwr, 0);
    rd_lit(8'h98, 32'h0, 32'h0F00, "R7 no wake status");
    // R9 long hold wakes
    @(negedge clk) wake[0] = 0; idle(60);
    chk(pwr == 1, "R9 wake on", pwr, 1);
    rd_lit(8'h98, 32'h0100, 32'h0F00, "R9 wake status bit 8");
    @(negedge clk) wake[0] = 1; idle(60);
    wr(8'h98, 32'h0001_01F1);
    rd_lit(8'h98, 32'h0, 32'h0F00, "R9 wake status cleared");

    // R8 disabled pin 1 has no effect
    wr(8'h44, 32'h80);
    @(negedge clk) time_v = T_AWAY; idle(2);
    @(negedge clk) time_v = T_ALM; idle(2);
    chk(pwr == 0, "R6 off again", pwr, 0);
    @(negedge clk) wake[1] = 0; idle(60);
    chk(pwr == 0, "R8 disabled pin", pwr, 0);
    @(negedge clk) wake[1] = 1;

    // R8 active-high pin 2
    @(negedge clk) wake[2] = 0; idle(60);
    wr(8'h98, 32'h0001_00B4); idle(10);
    chk(pwr == 0, "R8 inactive high pin", pwr, 0);
    @(negedge clk) wake[2] = 1; idle(60);
    chk(pwr == 1, "R8 active-high wake", pwr, 1);
    rd_lit(8'h98, 32'h0400, 32'h0F00, "R9 wake status bit 10");
    rd(8'h98, "R10 model word");
    rd(8'h44, "R4 model status");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule